// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Staged Updates

This block drives a set of pulse-width-modulated outputs. Software programs it through a simple 32-bit register port: one write strobe, an 8-bit byte address, write data and a combinational read-data return. Each channel has its own period, compare, dual compare and control words. It counts on ticks from one of a small bank of shared clock prescalers and can count in a sawtooth or a triangle pattern. A prescaler value is written indirectly: a select field in the common control word chooses which prescaler the scaler data word reaches.

The common control word also has one hold bit per channel. While a channel's hold bit is set, new period and compare values are kept in shadow storage and the running waveform keeps its old values. Clearing the hold bits in one write moves the staged values of every held channel into use on the same clock. Each channel can raise a pending flag on its period or compare event, thinned by a per-channel event divider. The interrupt output combines the pending flags of the channels that have their interrupt enabled.

Top module: `pwm_sync_top`

## Requirements
- R1: After reset every prescaler holds its all-ones value, all channel words, the common control word and the pending word read zero, and capability word 1 (0x0C) reads channel count minus one in bits 2:0 and prescaler count minus one in bits 15:13.
- R2: Common words decode at 0x00 control, 0x04 scaler data, 0x08 pending, 0x0C and 0x10 capability. Channel i has period at 0x20+16i, compare at +4, dual compare at +8 and control at +12.
- R3: While common control bit 12+i is set, values written to channel i's period and compare are readable but do not affect its output. Clearing the hold bits makes every held channel use its staged values from the same clock.
- R4: A write to 0x04 sets the prescaler chosen by common control bits 10:8, and reading 0x04 returns that prescaler. A prescaler set to V ticks once every V+1 clocks. A channel advances only on ticks from the prescaler chosen by its control bits 12:10.
- R5: With channel control bit 6 clear, the counter runs 0 up to period P and wraps to 0, and the output is active while the counter is below compare C. At one tick per clock it is active for C of every P+1 clocks.
- R6: With channel control bit 6 set, the counter runs up to P and back down to 0. At one tick per clock it is active for 2C-1 of every 2P clocks.
- R7: Channel control bit 1 inverts the output. When the channel (control bit 0) or the core (common control bit 0) is disabled, the output rests at the polarity level.
- R8: Writes to channel control bits 1 and 6 are ignored while the channel's enable bit is already set.
- R9: With the interrupt divider (channel control bits 20:15) at N, the pending bit of the channel is set once every N+1 events. The event is a period match when control bit 14 is clear and a compare match while counting up when it is set.
- R10: Writing 1 to bit i of the pending word clears channel i's pending bit, and writing 0 leaves it unchanged.
- R11: The interrupt output is high exactly when some pending bit is set whose channel has control bit 13 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest behaviour to reach is the staged commit. Two channels must be running on different prescalers while both are held, and new compare values must be written without any visible effect. One clear of the hold bits must then change the duty of both outputs, and this is judged only by counting active cycles over whole periods before and after the release. The bench sets this up by starting both channels first, counting duty to establish the old values, and only then setting the holds, writing, recounting and releasing. The interrupt divider and the event type are told apart by the number of clocks from enable to the pending flag: a compare event comes early in the period, a period event later, and a divider of two takes three periods.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    localparam logic [7:0] A_CTRL    = 8'h00;
    localparam logic [7:0] A_SCALE   = 8'h04;
    localparam logic [7:0] A_PEND    = 8'h08;
    localparam logic [7:0] A_CAP1    = 8'h0C;
    localparam logic [7:0] A_CAP2    = 8'h10;
    localparam logic [7:0] A_CH_BASE = 8'h20;

    typedef enum logic [1:0] {
        W_PER  = 2'd0,
        W_CMP  = 2'd1,
        W_DCMP = 2'd2,
        W_CTRL = 2'd3
    } ch_word_e;

    typedef enum logic {
        CNT_SAW = 1'b0,
        CNT_TRI = 1'b1
    } cnt_mode_e;

    typedef struct packed {
        logic [5:0] isc;
        logic       on_cmp;
        logic       ien;
        logic [2:0] psel;
        cnt_mode_e  mode;
        logic       inv;
        logic       en;
    } ch_cfg_t;

    function automatic ch_cfg_t cfg_from_word(input logic [31:0] w);
        ch_cfg_t c;
        c.en     = w[0];
        c.inv    = w[1];
        c.mode   = cnt_mode_e'(w[6]);
        c.psel   = w[12:10];
        c.ien    = w[13];
        c.on_cmp = w[14];
        c.isc    = w[20:15];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input ch_cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.en;
        w[1]     = c.inv;
        w[6]     = c.mode;
        w[12:10] = c.psel;
        w[13]    = c.ien;
        w[14]    = c.on_cmp;
        w[20:15] = c.isc;
        return w;
    endfunction

endpackage

// File: rtl/pwm_sync_prescaler.sv
module pwm_sync_prescaler #(
    parameter int NSC  = 2,
    parameter int SC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            wr_en,
    input  logic [2:0]      wr_idx,
    input  logic [SC_W-1:0] wr_val,
    input  logic [2:0]      rd_idx,
    output logic [SC_W-1:0] rd_val,
    output logic [NSC-1:0]  tick_o
);

    logic [SC_W-1:0] lims [NSC];

    for (genvar g = 0; g < NSC; g++) begin : g_sc
        logic [SC_W-1:0] lim;
        logic [SC_W-1:0] cnt;
        logic            sel;

        assign sel       = wr_en && (wr_idx == 3'(g));
        assign tick_o[g] = run && (cnt >= lim);
        assign lims[g]   = lim;

        always_ff @(posedge clk) begin
            if (rst) begin
                lim <= '1;
                cnt <= '0;
            end else begin
                if (sel) lim <= wr_val;
                if (!run || tick_o[g]) cnt <= '0;
                else                   cnt <= cnt + 1'b1;
            end
        end

        // R4
        tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
            (tick_o[g] && lim != '0 && !sel) |=> !tick_o[g]);
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NSC; k++)
            if (rd_idx == 3'(k)) rd_val = lims[k];
    end

endmodule

// File: rtl/pwm_sync_channel.sv
module pwm_sync_channel
    import pwm_sync_pkg::*;
#(
    parameter int NSC   = 2,
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           core_en,
    input  logic           hold,
    input  logic [NSC-1:0] tick_in,
    input  logic           wr_en,
    input  logic [1:0]     word,
    input  logic [31:0]    wdata,
    output logic [31:0]    rd_data,
    output logic           pwm_o,
    output logic           evt_o,
    output logic           ien_o
);

    ch_cfg_t          cfg, nc;
    logic [CNT_W-1:0] sh_per, sh_cmp, sh_dcmp;
    logic [CNT_W-1:0] act_per, act_cmp;
    logic [CNT_W-1:0] cnt;
    logic             up;
    logic [5:0]       icnt;
    logic             run, tick, rising, per_hit, cmp_hit, ev;
    logic             unused_wd;

    assign unused_wd = ^wdata[31:21];

    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < NSC; k++)
            if (cfg.psel == 3'(k)) tick = tick_in[k];
    end

    assign run     = core_en && cfg.en;
    assign rising  = (cfg.mode == CNT_SAW) || up;
    assign per_hit = run && tick && rising && (cnt == act_per);
    assign cmp_hit = run && tick && rising && (cnt == act_cmp);
    assign ev      = cfg.on_cmp ? cmp_hit : per_hit;
    assign evt_o   = ev && (icnt >= cfg.isc);
    assign ien_o   = cfg.ien;
    assign pwm_o   = cfg.inv ^ (run && (cnt < act_cmp));

    // control write: polarity and mode are frozen while enabled
    always_comb begin
        nc = cfg_from_word(wdata);
        if (cfg.en) begin
            nc.inv  = cfg.inv;
            nc.mode = cfg.mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            sh_per  <= '0;
            sh_cmp  <= '0;
            sh_dcmp <= '0;
            act_per <= '0;
            act_cmp <= '0;
        end else begin
            if (wr_en) begin
                case (ch_word_e'(word))
                    W_PER:   sh_per  <= wdata[CNT_W-1:0];
                    W_CMP:   sh_cmp  <= wdata[CNT_W-1:0];
                    W_DCMP:  sh_dcmp <= wdata[CNT_W-1:0];
                    default: cfg     <= nc;
                endcase
            end
            if (!hold) begin
                act_per <= sh_per;
                act_cmp <= sh_cmp;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            up   <= 1'b1;
            icnt <= '0;
        end else begin
            if (ev) icnt <= (icnt >= cfg.isc) ? 6'd0 : icnt + 6'd1;
            if (tick) begin
                if (cfg.mode == CNT_SAW) begin
                    up  <= 1'b1;
                    cnt <= (cnt >= act_per) ? '0 : cnt + 1'b1;
                end else if (up) begin
                    if (cnt >= act_per) begin
                        up  <= 1'b0;
                        cnt <= (cnt != '0) ? cnt - 1'b1 : '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (cnt == '0) begin
                    up  <= 1'b1;
                    cnt <= (act_per != '0) ? CNT_W'(1) : '0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (ch_word_e'(word))
            W_PER:   rd_data = 32'(sh_per);
            W_CMP:   rd_data = 32'(sh_cmp);
            W_DCMP:  rd_data = 32'(sh_dcmp);
            default: rd_data = cfg_to_word(cfg);
        endcase
    end

    // R8
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.en |=> ($stable(cfg.inv) && $stable(cfg.mode)));

    // R3
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(act_per) && $stable(act_cmp)));

endmodule

// File: rtl/pwm_sync_top.sv
module pwm_sync_top
    import pwm_sync_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NSC   = 2,
    parameter int CNT_W = 16,
    parameter int SC_W  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [7:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic           irq
);

    localparam logic [3:0] NCH_B = 4'(NCH);

    logic            core_en;
    logic [2:0]      sc_sel;
    logic [NCH-1:0]  hold;
    logic [NCH-1:0]  pend;
    logic [NCH-1:0]  ch_evt, ch_ien, ch_we;
    logic [NSC-1:0]  ticks;
    logic [SC_W-1:0] sc_rd;
    logic [31:0]     ch_rd [NCH];
    logic [31:0]     ch_rsel, cap1;
    logic [7:0]      off;
    logic            in_ch, unused_off;

    assign off        = reg_addr - A_CH_BASE;
    assign in_ch      = (reg_addr >= A_CH_BASE) && (off[7:4] < NCH_B);
    assign unused_off = ^off[1:0];

    pwm_sync_prescaler #(.NSC(NSC), .SC_W(SC_W)) u_scale (
        .clk    (clk),
        .rst    (rst),
        .run    (core_en),
        .wr_en  (reg_we && reg_addr == A_SCALE),
        .wr_idx (sc_sel),
        .wr_val (reg_wdata[SC_W-1:0]),
        .rd_idx (sc_sel),
        .rd_val (sc_rd),
        .tick_o (ticks)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_we[g] = reg_we && in_ch && (off[6:4] == 3'(g));

        pwm_sync_channel #(.NSC(NSC), .CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .core_en (core_en),
            .hold    (hold[g]),
            .tick_in (ticks),
            .wr_en   (ch_we[g]),
            .word    (off[3:2]),
            .wdata   (reg_wdata),
            .rd_data (ch_rd[g]),
            .pwm_o   (pwm_out[g]),
            .evt_o   (ch_evt[g]),
            .ien_o   (ch_ien[g])
        );

        always_ff @(posedge clk) begin
            if (rst) pend[g] <= 1'b0;
            else     pend[g] <= (pend[g] && !(reg_we && reg_addr == A_PEND && reg_wdata[g]))
                                || ch_evt[g];
        end

        // R10
        pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == A_PEND && reg_wdata[g] && !ch_evt[g]) |=> !pend[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_en <= 1'b0;
            sc_sel  <= '0;
            hold    <= '0;
        end else if (reg_we && reg_addr == A_CTRL) begin
            core_en <= reg_wdata[0];
            sc_sel  <= reg_wdata[10:8];
            hold    <= reg_wdata[12 +: NCH];
        end
    end

    assign irq = |(pend & ch_ien);

    always_comb begin
        cap1         = '0;
        cap1[2:0]    = 3'(NCH - 1);
        cap1[15:13]  = 3'(NSC - 1);
        ch_rsel      = '0;
        for (int k = 0; k < NCH; k++)
            if (off[6:4] == 3'(k)) ch_rsel = ch_rd[k];
    end

    always_comb begin
        reg_rdata = '0;
        if (in_ch) begin
            reg_rdata = ch_rsel;
        end else begin
            case (reg_addr)
                A_CTRL: begin
                    reg_rdata[0]          = core_en;
                    reg_rdata[10:8]       = sc_sel;
                    reg_rdata[12 +: NCH]  = hold;
                end
                A_SCALE: reg_rdata = 32'(sc_rd);
                A_PEND:  reg_rdata = 32'(pend);
                A_CAP1:  reg_rdata = cap1;
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: tb/tb_pwm_sync_top.sv
module tb_pwm_sync_top;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_we = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] pwm_out;
    logic           irq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pwm_sync_top #(.NCH(NCH), .NSC(2), .CNT_W(16), .SC_W(16)) dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    function automatic logic [7:0] ch_a(input int ch, input int w);
        return 8'(32 + 16 * ch + 4 * w);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int got, input int lo, input int hi);
        checks++;
        if (got < lo || got > hi) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) c++;
        end
    endtask

    // clocks from the enabling write until pending bit ch is set
    task automatic wait_pend(input int ch, output int k);
        logic [31:0] d;
        k = 0;
        rd(8'h08, d);
        while (!d[ch] && k < 100) begin
            @(negedge clk);
            k++;
            rd(8'h08, d);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); chk("R1 ctrl reset", d, 32'h0);
        rd(8'h04, d); chk("R1 scaler reset max", d, 32'h0000FFFF);
        rd(8'h08, d); chk("R1 pending reset", d, 32'h0);
        rd(8'h0C, d); chk("R1 R2 capability word", d, 32'h00002003);
        rd(ch_a(2, 0), d); chk("R1 period reset", d, 32'h0);
        rd(ch_a(3, 3), d); chk("R1 chan ctrl reset", d, 32'h0);
        chk("R1 outputs reset", 32'(pwm_out), 32'h0);
        chk("R11 irq reset", 32'(irq), 32'h0);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        int c;
        wr(8'h00, 32'h100);
        wr(8'h04, 32'd1);
        rd(8'h04, d); chk("R4 scaler 1 readback", d, 32'd1);
        wr(8'h00, 32'h000);
        wr(8'h04, 32'd0);
        rd(8'h04, d); chk("R4 scaler 0 readback", d, 32'd0);
        wr(8'h00, 32'h1);
        wr(ch_a(0, 0), 32'd4);
        wr(ch_a(0, 1), 32'd2);
        wr(ch_a(0, 2), 32'd7);
        rd(ch_a(0, 2), d); chk("R2 dual compare word", d, 32'd7);
        wr(ch_a(0, 3), 32'h1);
        idle(6);
        count_high(0, 10, c); chk("R5 sawtooth duty", 32'(c), 32'd4);
        wr(ch_a(1, 0), 32'd4);
        wr(ch_a(1, 1), 32'd2);
        wr(ch_a(1, 3), 32'h401);
        idle(12);
        count_high(1, 20, c); chk("R4 slow prescaler duty", 32'(c), 32'd8);
    endtask

    task automatic t_sym;
        int c;
        wr(ch_a(2, 0), 32'd4);
        wr(ch_a(2, 1), 32'd2);
        wr(ch_a(2, 3), 32'h41);
        idle(10);
        count_high(2, 16, c); chk("R6 triangle duty", 32'(c), 32'd6);
    endtask

    task automatic t_pol;
        logic [31:0] d;
        int c;
        wr(ch_a(3, 3), 32'h2);
        idle(2);
        chk("R7 disabled rests at polarity", 32'(pwm_out[3]), 32'h1);
        wr(ch_a(3, 0), 32'd4);
        wr(ch_a(3, 1), 32'd2);
        wr(ch_a(3, 3), 32'h3);
        idle(6);
        count_high(3, 10, c); chk("R7 inverted duty", 32'(c), 32'd6);
        wr(ch_a(3, 3), 32'h1);
        rd(ch_a(3, 3), d); chk("R8 polarity write ignored", d, 32'h3);
        wr(ch_a(3, 3), 32'h41);
        rd(ch_a(3, 3), d); chk("R8 mode write ignored", d, 32'h3);
        count_high(3, 10, c); chk("R8 output still inverted", 32'(c), 32'd6);
        wr(ch_a(3, 3), 32'h0);
        rd(ch_a(3, 3), d); chk("R8 disable keeps polarity", d, 32'h2);
        wr(ch_a(3, 3), 32'h0);
        rd(ch_a(3, 3), d); chk("R8 polarity free when disabled", d, 32'h0);
        wr(8'h00, 32'h0);
        count_high(0, 10, c); chk("R7 core disabled output idle", 32'(c), 32'd0);
        wr(8'h00, 32'h1);
    endtask

    task automatic t_hold;
        logic [31:0] d;
        int c;
        idle(12);
        wr(8'h00, 32'h3001);
        wr(ch_a(0, 1), 32'd4);
        wr(ch_a(1, 1), 32'd4);
        rd(ch_a(0, 1), d); chk("R3 staged compare readable", d, 32'd4);
        idle(3);
        count_high(0, 10, c); chk("R3 held ch0 keeps old duty", 32'(c), 32'd4);
        count_high(1, 20, c); chk("R3 held ch1 keeps old duty", 32'(c), 32'd8);
        wr(8'h00, 32'h1);
        idle(12);
        count_high(0, 10, c); chk("R3 ch0 new duty after release", 32'(c), 32'd8);
        count_high(1, 20, c); chk("R3 ch1 new duty after release", 32'(c), 32'd16);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        int k;
        wr(ch_a(3, 0), 32'd6);
        wr(ch_a(3, 1), 32'd2);
        wr(8'h08, 32'h8);
        wr(ch_a(3, 3), 32'h2001);
        wait_pend(3, k); chk_rng("R9 period event timing", k, 6, 8);
        chk("R11 irq with enabled pending", 32'(irq), 32'h1);
        wr(8'h08, 32'h0);
        rd(8'h08, d); chk("R10 write zero keeps pending", 32'(d[3]), 32'h1);
        wr(8'h08, 32'h8);
        rd(8'h08, d); chk("R10 write one clears pending", 32'(d[3]), 32'h0);
        chk("R11 irq low after clear", 32'(irq), 32'h0);
        wr(ch_a(3, 3), 32'h0);
        wr(8'h08, 32'h8);
        wr(ch_a(3, 3), 32'h6001);
        wait_pend(3, k); chk_rng("R9 compare event timing", k, 2, 4);
        wr(ch_a(3, 3), 32'h0);
        wr(8'h08, 32'h8);
        wr(ch_a(3, 3), 32'h12001);
        wait_pend(3, k); chk_rng("R9 divider of two", k, 20, 22);
        wr(ch_a(3, 3), 32'h0);
        wr(8'h08, 32'h8);
        wr(ch_a(3, 3), 32'h1);
        idle(10);
        rd(8'h08, d); chk("R11 pending without enable", 32'(d[3]), 32'h1);
        chk("R11 irq masked", 32'(irq), 32'h0);
    endtask

    bit done = 1'b0;

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_prescale;
        t_sym;
        t_pol;
        t_hold;
        t_irq;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule